// File: doc/BRIEF.md
# Multi-Bank DRAM Read Scheduler

This block takes read requests, each tagged with a bank index, a row address and a caller tag, and turns them into precharge, activate and column-read commands for a DRAM model with many banks. All banks share one data channel. Requests wait in an age-ordered queue. Each bank receives the oldest waiting request for it once the bank goes idle. A bank that already holds the requested row open skips straight to the column read. Any other request opens its row with a precharge followed by an activate.

Every bank counts its own spacing between commands. A single channel arbiter passes at most one column read per data-burst interval, and it picks the oldest bank whose timing allows the read. Requests aimed at different banks therefore overlap their row opening, and their data bursts follow each other on the channel with no gap. Each request completes with a one-cycle done pulse that carries its tag. The pulse comes when the request's burst ends.

Top module: `dram_bank_sched`

## Requirements
- R1: Out of reset, req_ready is 1 and resp_valid, cmd_pre, cmd_act and cmd_cas are all 0.
- R2: A request to a bank with no matching open row issues cmd_pre bit b (bit index = bank) 2 cycles after acceptance, cmd_act bit b 13 cycles after the precharge, and cmd_cas with cmd_cas_bank = b 13 cycles after the activate. An isolated request of this kind completes 45 cycles after acceptance.
- R3: A request whose row is already open in its idle bank issues no precharge and no activate, and completes 19 cycles after acceptance.
- R4: Two cmd_cas pulses are at least 4 cycles apart.
- R5: Two precharges to the same bank are at least 39 cycles apart, and a precharge follows that bank's last column read by at least 13 cycles.
- R6: Row misses to distinct idle banks, accepted on consecutive cycles, complete exactly 4 cycles apart, the first 45 cycles after the first acceptance.
- R7: When several banks are ready for a column read, the one holding the earliest-accepted request wins. Requests to the same bank complete in acceptance order.
- R8: resp_valid is a one-cycle pulse 17 cycles after the column read, and resp_tag carries the tag given with that request.
- R9: With 8 requests waiting in the queue, req_ready is 0 and no further request is taken until an entry leaves the queue.
- R10: A column read to a bank comes no earlier than 13 cycles after that bank's most recent activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_bank | input | BW | Target bank |
| req_row | input | ROW_W | Target row |
| req_tag | input | TAG_W | Caller tag |
| cmd_pre | output | NBANK | Precharge strobe, one bit per bank |
| cmd_act | output | NBANK | Activate strobe, one bit per bank |
| cmd_cas | output | 1 | Column read strobe |
| cmd_cas_bank | output | BW | Bank of the column read |
| resp_valid | output | 1 | Request finished its data burst |
| resp_tag | output | TAG_W | Tag of the finished request |

## Verification
The hardest situation to reach is a full queue while the banks are still busy. The stimulus sends ten same-row requests to one bank on back-to-back cycles. The first one holds the bank for its whole row opening, so the queue fills and ready drops. The rest then stream out as row hits spaced by the channel interval. The age-ordered arbitration is reached by sending row misses to all banks in descending bank order. The column reads must then follow acceptance order and not bank index.

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
  parameter int NBANK   = 8,
  parameter int ROW_W   = 10,
  parameter int TAG_W   = 4,
  parameter int QDEPTH  = 8,
  parameter int T_RP    = 13,
  parameter int T_RCD   = 13,
  parameter int T_RTP   = 13,
  parameter int T_RC    = 39,
  parameter int T_CL    = 13,
  parameter int T_BURST = 4,
  localparam int BW     = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [TAG_W-1:0] req_tag,
  output logic [NBANK-1:0] cmd_pre,
  output logic [NBANK-1:0] cmd_act,
  output logic             cmd_cas,
  output logic [BW-1:0]    cmd_cas_bank,
  output logic             resp_valid,
  output logic [TAG_W-1:0] resp_tag
);
  localparam int QW    = $clog2(QDEPTH + 1);
  localparam int QIW   = $clog2(QDEPTH);
  localparam int CW    = $clog2(T_RC + 2);
  localparam int SW    = $clog2(QDEPTH + NBANK) + 2;
  localparam int HW    = $clog2(T_BURST + 1);
  localparam int T_RAS = T_RC - T_RP;
  localparam int RLAT  = T_CL + T_BURST;
  localparam logic [CW-1:0] SMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_PREQ, S_ACTW, S_RDY} bst_t;

  logic [BW-1:0]    q_bank [QDEPTH];
  logic [ROW_W-1:0] q_row  [QDEPTH];
  logic [TAG_W-1:0] q_tag  [QDEPTH];
  logic [SW-1:0]    q_seq  [QDEPTH];
  logic [QW-1:0]    q_cnt;
  logic [SW-1:0]    seq_now;

  bst_t             b_st   [NBANK];
  logic [CW-1:0]    b_cnt  [NBANK];
  logic [CW-1:0]    b_sact [NBANK];
  logic [CW-1:0]    b_scas [NBANK];
  logic             b_open [NBANK];
  logic [ROW_W-1:0] b_orow [NBANK];
  logic [ROW_W-1:0] b_row  [NBANK];
  logic [TAG_W-1:0] b_tag  [NBANK];
  logic [SW-1:0]    b_seq  [NBANK];

  logic [HW-1:0]    chan_cnt;
  logic [RLAT-1:0]  pipe_v;
  logic [TAG_W-1:0] pipe_tag [RLAT];

  logic             acc, dsp, d_hit, gany, gnt;
  logic [QIW-1:0]   sel;
  logic [QIW-1:0]   wr_idx;
  logic [BW-1:0]    gsel;
  logic [SW-1:0]    best;
  logic [NBANK-1:0] pre_v, act_v;

  assign req_ready = q_cnt < QW'(QDEPTH);
  assign acc       = req_valid && req_ready;
  assign wr_idx    = QIW'(q_cnt - QW'(dsp));

  always_comb begin
    dsp = 1'b0;
    sel = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (QW'(i) < q_cnt && b_st[q_bank[i]] == S_IDLE) begin
        dsp = 1'b1;
        sel = QIW'(i);
      end
  end

  assign d_hit = b_open[q_bank[sel]] && (b_orow[q_bank[sel]] == q_row[sel]);

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      pre_v[b] = (b_st[b] == S_PREQ) && (b_sact[b] >= CW'(T_RAS)) && (b_scas[b] >= CW'(T_RTP));
      act_v[b] = (b_st[b] == S_ACTW) && (b_cnt[b] == '0);
    end
  end

  always_comb begin
    gany = 1'b0;
    gsel = '0;
    best = '0;
    for (int b = 0; b < NBANK; b++)
      if (b_st[b] == S_RDY && b_cnt[b] == '0 &&
          (!gany || (seq_now - b_seq[b]) > best)) begin
        gany = 1'b1;
        gsel = BW'(b);
        best = seq_now - b_seq[b];
      end
  end

  assign gnt          = gany && (chan_cnt == '0);
  assign cmd_pre      = pre_v;
  assign cmd_act      = act_v;
  assign cmd_cas      = gnt;
  assign cmd_cas_bank = gsel;
  assign resp_valid   = pipe_v[RLAT-1];
  assign resp_tag     = pipe_tag[RLAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_cnt   <= '0;
      seq_now <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        q_bank[i] <= '0;
        q_row[i]  <= '0;
        q_tag[i]  <= '0;
        q_seq[i]  <= '0;
      end
    end else begin
      q_cnt <= q_cnt + QW'(acc) - QW'(dsp);
      for (int i = 0; i < QDEPTH - 1; i++)
        if (dsp && QIW'(i) >= sel) begin
          q_bank[i] <= q_bank[i+1];
          q_row[i]  <= q_row[i+1];
          q_tag[i]  <= q_tag[i+1];
          q_seq[i]  <= q_seq[i+1];
        end
      if (acc) begin
        q_bank[wr_idx] <= req_bank;
        q_row[wr_idx]  <= req_row;
        q_tag[wr_idx]  <= req_tag;
        q_seq[wr_idx]  <= seq_now;
        seq_now        <= seq_now + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        b_st[b]   <= S_IDLE;
        b_cnt[b]  <= '0;
        b_sact[b] <= SMAX;
        b_scas[b] <= SMAX;
        b_open[b] <= 1'b0;
        b_orow[b] <= '0;
        b_row[b]  <= '0;
        b_tag[b]  <= '0;
        b_seq[b]  <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (b_sact[b] != SMAX) b_sact[b] <= b_sact[b] + 1'b1;
        if (b_scas[b] != SMAX) b_scas[b] <= b_scas[b] + 1'b1;
        case (b_st[b])
          S_IDLE:
            if (dsp && q_bank[sel] == BW'(b)) begin
              b_row[b] <= q_row[sel];
              b_tag[b] <= q_tag[sel];
              b_seq[b] <= q_seq[sel];
              b_cnt[b] <= '0;
              b_st[b]  <= d_hit ? S_RDY : S_PREQ;
            end
          S_PREQ:
            if (pre_v[b]) begin
              b_st[b]   <= S_ACTW;
              b_cnt[b]  <= CW'(T_RP - 1);
              b_open[b] <= 1'b0;
            end
          S_ACTW:
            if (b_cnt[b] == '0) begin
              b_st[b]   <= S_RDY;
              b_cnt[b]  <= CW'(T_RCD - 1);
              b_open[b] <= 1'b1;
              b_orow[b] <= b_row[b];
              b_sact[b] <= CW'(1);
            end else begin
              b_cnt[b] <= b_cnt[b] - 1'b1;
            end
          S_RDY:
            if (b_cnt[b] != '0) begin
              b_cnt[b] <= b_cnt[b] - 1'b1;
            end else if (gnt && gsel == BW'(b)) begin
              b_st[b]   <= S_IDLE;
              b_scas[b] <= CW'(1);
            end
          default: b_st[b] <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_cnt <= '0;
      pipe_v   <= '0;
      for (int i = 0; i < RLAT; i++) pipe_tag[i] <= '0;
    end else begin
      if (gnt) chan_cnt <= HW'(T_BURST - 1);
      else if (chan_cnt != '0) chan_cnt <= chan_cnt - 1'b1;
      pipe_v      <= {pipe_v[RLAT-2:0], gnt};
      pipe_tag[0] <= b_tag[gsel];
      for (int i = 1; i < RLAT; i++) pipe_tag[i] <= pipe_tag[i-1];
    end
  end
endmodule

module dram_bank_sched_chk #(
  parameter int NBANK   = 8,
  parameter int T_RP    = 13,
  parameter int T_RCD   = 13,
  parameter int T_RTP   = 13,
  parameter int T_RC    = 39,
  parameter int T_BURST = 4,
  localparam int BW     = $clog2(NBANK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] cmd_pre,
  input logic [NBANK-1:0] cmd_act,
  input logic             cmd_cas,
  input logic [BW-1:0]    cmd_cas_bank,
  input logic             resp_valid
);
  localparam int CW = $clog2(T_RC + 2);
  localparam logic [CW-1:0] SMAX = '1;

  logic [CW-1:0] ch_gap;
  logic [CW-1:0] s_pre [NBANK];
  logic [CW-1:0] s_act [NBANK];
  logic [CW-1:0] s_cas [NBANK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_gap <= SMAX;
      for (int b = 0; b < NBANK; b++) begin
        s_pre[b] <= SMAX;
        s_act[b] <= SMAX;
        s_cas[b] <= SMAX;
      end
    end else begin
      ch_gap <= cmd_cas ? CW'(1) : (ch_gap == SMAX ? SMAX : ch_gap + 1'b1);
      for (int b = 0; b < NBANK; b++) begin
        s_pre[b] <= cmd_pre[b] ? CW'(1) : (s_pre[b] == SMAX ? SMAX : s_pre[b] + 1'b1);
        s_act[b] <= cmd_act[b] ? CW'(1) : (s_act[b] == SMAX ? SMAX : s_act[b] + 1'b1);
        s_cas[b] <= (cmd_cas && cmd_cas_bank == BW'(b)) ? CW'(1)
                  : (s_cas[b] == SMAX ? SMAX : s_cas[b] + 1'b1);
      end
    end
  end

  a_r4_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cas |-> ch_gap >= CW'(T_BURST));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    a_r5_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pre[b] |-> s_pre[b] >= CW'(T_RC));
    a_r5_pre_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pre[b] |-> s_cas[b] >= CW'(T_RTP));
    a_r2_act_delay: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_act[b] |-> s_pre[b] == CW'(T_RP));
    a_r10_cas_after_act: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_cas && cmd_cas_bank == BW'(b)) |-> s_act[b] >= CW'(T_RCD));
  end
endmodule

bind dram_bank_sched dram_bank_sched_chk #(
  .NBANK(NBANK), .T_RP(T_RP), .T_RCD(T_RCD), .T_RTP(T_RTP), .T_RC(T_RC), .T_BURST(T_BURST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_pre(cmd_pre), .cmd_act(cmd_act),
  .cmd_cas(cmd_cas), .cmd_cas_bank(cmd_cas_bank), .resp_valid(resp_valid)
);

// File: tb/dram_bank_sched_bench.sv
module dram_bank_sched_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [2:0] req_bank = '0;
  logic [9:0] req_row = '0;
  logic [3:0] req_tag = '0;
  logic [7:0] cmd_pre, cmd_act;
  logic       cmd_cas;
  logic [2:0] cmd_cas_bank;
  logic       resp_valid;
  logic [3:0] resp_tag;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int rowcmds = 0;
  int   sb_tag[$];
  int   sb_at[$];
  string sb_r[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_n) rowcmds <= rowcmds + $countones(cmd_pre) + $countones(cmd_act);

  dram_bank_sched u_dram_bank_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_tag(req_tag),
    .cmd_pre(cmd_pre), .cmd_act(cmd_act), .cmd_cas(cmd_cas), .cmd_cas_bank(cmd_cas_bank),
    .resp_valid(resp_valid), .resp_tag(resp_tag)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send(input int bnk, input int row, input int tg, input int at, input string r);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_bank  = bnk[2:0];
    req_row   = row[9:0];
    req_tag   = tg[3:0];
    sb_tag.push_back(tg);
    sb_at.push_back(at);
    sb_r.push_back(r);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (sb_tag.size() == 0) begin
        check(1'b0, "R8 unexpected response", int'(resp_tag), -1);
      end else begin
        int et, ea;
        string er;
        et = sb_tag.pop_front();
        ea = sb_at.pop_front();
        er = sb_r.pop_front();
        check(int'(resp_tag) == et, {er, " tag"}, int'(resp_tag), et);
        check(cyc == ea, {er, " completion cycle"}, cyc, ea);
      end
    end
  end

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=0 pending", sb_tag.size());
    summary();
    $finish;
  end

  initial begin
    int k;
    repeat (5) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R1 resp", int'(resp_valid), 0);
    check(cmd_pre == '0 && cmd_act == '0, "R1 row cmds", int'(cmd_pre | cmd_act), 0);
    check(cmd_cas == 1'b0, "R1 cas", int'(cmd_cas), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && cmd_cas == 1'b0, "R1 after reset", int'(req_ready), 1);

    // R2: closed bank miss
    k = cyc;
    send(0, 5, 1, k + 45, "R2");
    wait_to(k + 2);
    check(cmd_pre == 8'h01, "R2 precharge", int'(cmd_pre), 1);
    wait_to(k + 15);
    check(cmd_act == 8'h01, "R2 activate", int'(cmd_act), 1);
    wait_to(k + 28);
    check(cmd_cas && cmd_cas_bank == 3'd0, "R2 column read", int'(cmd_cas), 1);
    wait_to(k + 100);

    // R3: open row hit
    k = cyc;
    begin
      int base;
      base = rowcmds;
      send(0, 5, 2, k + 19, "R3");
      wait_to(k + 40);
      check(rowcmds == base, "R3 no precharge or activate", rowcmds - base, 0);
    end
    wait_to(k + 100);

    // R2: miss to open bank with a different row
    k = cyc;
    send(0, 9, 3, k + 45, "R2 open miss");
    wait_to(k + 2);
    check(cmd_pre == 8'h01, "R2 open miss precharge", int'(cmd_pre), 1);
    wait_to(k + 100);

    // R5: two misses to the same bank
    k = cyc;
    send(5, 20, 4, k + 45, "R5 first");
    send(5, 21, 5, k + 84, "R5 second");
    wait_to(k + 40);
    check(cmd_pre[5] == 1'b0, "R5 early precharge", int'(cmd_pre[5]), 0);
    wait_to(k + 41);
    check(cmd_pre[5] == 1'b1, "R5 spaced precharge", int'(cmd_pre[5]), 1);
    wait_to(k + 130);

    // R7 + R3: same bank, same row, in order
    k = cyc;
    send(6, 3, 6, k + 45, "R7 first");
    send(6, 3, 7, k + 49, "R7 hit behind miss");
    wait_to(k + 100);

    // R6 + R7: all banks, descending bank order
    k = cyc;
    for (int i = 0; i < 8; i++) send(7 - i, 100 + i, i, k + 45 + 4 * i, "R6");
    wait_to(k + 28);
    check(cmd_cas && cmd_cas_bank == 3'd7, "R7 oldest first", int'(cmd_cas_bank), 7);
    wait_to(k + 32);
    check(cmd_cas && cmd_cas_bank == 3'd6, "R7 second oldest", int'(cmd_cas_bank), 6);
    wait_to(k + 120);

    // R9: queue fills behind a busy bank
    k = cyc;
    fork
      for (int j = 0; j < 10; j++) send(7, 1, j + 1, k + 45 + 4 * j, "R9");
      begin
        wait_to(k + 20);
        check(req_ready == 1'b0, "R9 ready low when full", int'(req_ready), 0);
      end
    join
    wait_to(k + 150);
    check(sb_tag.size() == 0, "R8 all responses seen", sb_tag.size(), 0);
    summary();
    $finish;
  end
endmodule